// File: doc/BRIEF.md
# Seconds Prescaler With Test Clock

This block turns a slow time base into a once-per-second strobe for the timekeeping counters of a real-time clock. In normal operation it counts single-cycle 64 Hz strobes arriving in the system clock domain. When the test-mode input is set, those strobes are ignored. A slow clock applied from outside is used in their place. That external clock is brought into the system domain through a two-flop synchronizer, and each of its rising edges advances the prescaler.

The prescaler is a 6-bit binary counter. The seconds strobe is raised for one system clock cycle each time the counter steps from 31 to 32, which is the rising transition of its most significant bit. A stop input forces the counter to zero and holds it there. Because the strobe sits at the half-way point of the count, the first strobe after stop is released comes 32 edges later, and every following strobe comes 64 edges after the one before. Switching into or out of test mode does not touch the count. The phase held at that moment carries on.

The current prescaler phase is also driven out, so that the calendar logic and the bench can see it.

Top module: `sec_prescaler`

## Requirements
- R1: While reset is held (rst_ni low), phase_o is 0 and sec_pulse_o is 0.
- R2: With test_en_i = 0, each cycle with tick64_i = 1 (and stop_i = 0) increments phase_o by one, and ext_clk_i has no effect on phase_o.
- R3: With test_en_i = 1, each rising edge of ext_clk_i increments phase_o by one, and tick64_i has no effect on phase_o.
- R4: sec_pulse_o is high for exactly one system clock cycle, in the cycle in which phase_o has just stepped from 31 to 32. In steady counting, one pulse occurs per 64 advances.
- R5: While stop_i = 1, phase_o is 0 from the next cycle on, no advance source changes it, and sec_pulse_o stays 0.
- R6: After stop_i is released, the first pulse follows the 32nd rising edge and the second pulse follows the 96th.
- R7: A change of test_en_i leaves phase_o at the value it held.
- R8: phase_o wraps from 63 to 0 on the next advance.
- R9: An external clock with 300 ns HIGH width and 1000 ns period is counted edge for edge at a 50 MHz system clock. ext_clk_i passes through two synchronizing flops, so an edge reaches phase_o three system cycles after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least about 4 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick64_i | input | 1 | Single-cycle 64 Hz strobe, used in normal mode |
| test_en_i | input | 1 | 1 selects the external clock as the prescaler source |
| stop_i | input | 1 | 1 clears the prescaler and holds it at zero |
| ext_clk_i | input | 1 | Asynchronous external test clock |
| sec_pulse_o | output | 1 | One-cycle seconds increment strobe |
| phase_o | output | 6 | Current prescaler count |

## Verification
A wrong phase shows on phase_o in the cycle after the advance that caused it. It also moves the seconds strobe by the same number of edges, so a dropped or doubled edge delays or advances every later pulse. A stuck synchronizer or a wrong source select leaves phase_o frozen, or makes it move on the wrong input, within three system cycles of the offending stimulus. A misplaced pulse decode shows up at the first release from stop, because the pulse no longer comes after edge 32 and edge 96.

// File: rtl/sec_prescaler_pkg.sv
package sec_prescaler_pkg;
  localparam int unsigned PHASE_W = 6;
  typedef logic [PHASE_W-1:0] phase_t;

  // next value of a wrapping binary phase counter
  function automatic phase_t phase_step(input phase_t cur);
    return phase_t'(cur + phase_t'(1));
  endfunction

  // true when an advance from cur raises the top stage of the counter
  function automatic logic top_stage_rises(input phase_t cur);
    phase_t nxt;
    nxt = phase_step(cur);
    return nxt[PHASE_W-1] & ~cur[PHASE_W-1];
  endfunction
endpackage

// File: rtl/sp_edge_sync.sv
module sp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sp_src_sel.sv
module sp_src_sel (
  input  logic test_en_i,
  input  logic tick64_i,
  input  logic ext_rise_i,
  output logic adv_o
);
  always_comb begin
    if (test_en_i) adv_o = ext_rise_i;
    else           adv_o = tick64_i;
  end
endmodule

// File: rtl/sp_divider.sv
module sp_divider
  import sec_prescaler_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   adv_i,
  input  logic   stop_i,
  output phase_t phase_o,
  output logic   pulse_o
);
  phase_t phase_q;
  logic   pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pulse_q <= 1'b0;
    end else if (stop_i) begin
      phase_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= adv_i & top_stage_rises(phase_q);
      if (adv_i) phase_q <= phase_step(phase_q);
    end
  end

  assign phase_o = phase_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
  import sec_prescaler_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick64_i,
  input  logic               test_en_i,
  input  logic               stop_i,
  input  logic               ext_clk_i,
  output logic               sec_pulse_o,
  output logic [PHASE_W-1:0] phase_o
);
  logic   ext_rise_w;
  logic   adv_w;
  phase_t phase_w;

  sp_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_clk_i),
    .rise_o  (ext_rise_w)
  );

  sp_src_sel sel_i (
    .test_en_i  (test_en_i),
    .tick64_i   (tick64_i),
    .ext_rise_i (ext_rise_w),
    .adv_o      (adv_w)
  );

  sp_divider div_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv_w),
    .stop_i  (stop_i),
    .phase_o (phase_w),
    .pulse_o (sec_pulse_o)
  );

  assign phase_o = phase_w;
endmodule

// File: rtl/sec_prescaler_chk.sv
module sec_prescaler_chk
  import sec_prescaler_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               stop_i,
  input logic               adv_i,
  input logic               sec_pulse_o,
  input logic [PHASE_W-1:0] phase_o
);
  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (phase_o == '0 && !sec_pulse_o));

  assert_advance_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && adv_i) |=> phase_o == PHASE_W'($past(phase_o) + 1));

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && !adv_i) |=> $stable(phase_o));

  assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_o |=> !sec_pulse_o);

  assert_pulse_at_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_o |-> phase_o == PHASE_W'(1 << (PHASE_W-1)));

  assert_stop_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (phase_o == '0 && !sec_pulse_o));
endmodule

bind sec_prescaler sec_prescaler_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stop_i      (stop_i),
  .adv_i       (adv_w),
  .sec_pulse_o (sec_pulse_o),
  .phase_o     (phase_o)
);

// File: tb/sec_prescaler_tb_top.sv
module sec_prescaler_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick64_i = 1'b0;
  logic       test_en_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       sec_pulse_o;
  logic [5:0] phase_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  sec_prescaler dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick64_i(tick64_i), .test_en_i(test_en_i),
    .stop_i(stop_i), .ext_clk_i(ext_clk_i), .sec_pulse_o(sec_pulse_o), .phase_o(phase_o)
  );

  always @(negedge clk_i) if (rst_ni && sec_pulse_o) pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 300 ns high, 700 ns low at 20 ns per cycle (R9)
  task automatic ext_edge();
    @(negedge clk_i) ext_clk_i = 1'b1;
    repeat (15) @(negedge clk_i);
    ext_clk_i = 1'b0;
    repeat (35) @(negedge clk_i);
  endtask

  task automatic tick();
    @(negedge clk_i) tick64_i = 1'b1;
    @(negedge clk_i) tick64_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  function automatic int exp_pulses(input int n);
    return (n < 32) ? 0 : 1 + (n - 32) / 64;
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 phase", int'(phase_o), 0);
    check("R1 pulse", int'(sec_pulse_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2: normal mode counts strobes, ignores the external clock
    for (int i = 1; i <= 10; i++) begin
      tick();
      check("R2 tick advance", int'(phase_o), i);
    end
    for (int i = 0; i < 3; i++) ext_edge();
    check("R2 ext ignored", int'(phase_o), 10);

    // R7: mode switch keeps the phase
    @(negedge clk_i) test_en_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R7 entry keeps phase", int'(phase_o), 10);

    // R3: test mode ignores strobes
    for (int i = 0; i < 3; i++) tick();
    check("R3 tick ignored", int'(phase_o), 10);
    ext_edge();
    check("R3 ext advance", int'(phase_o), 11);

    // R5: stop clears and holds
    @(negedge clk_i) stop_i = 1'b1;
    @(negedge clk_i);
    check("R5 cleared", int'(phase_o), 0);
    pulses = 0;
    for (int i = 0; i < 70; i++) ext_edge();
    check("R5 held at zero", int'(phase_o), 0);
    check("R5 no pulse", pulses, 0);

    // R6/R4/R8/R9: sweep of edges from release
    @(negedge clk_i) stop_i = 1'b0;
    pulses = 0;
    for (int n = 1; n <= 200; n++) begin
      ext_edge();
      check("R9 phase per edge", int'(phase_o), n % 64);
      check((n == 32 || n == 96) ? "R6 pulse timing" : "R4 pulse count", pulses, exp_pulses(n));
    end

    // R7: leaving test mode keeps phase (200 % 64 = 8), then strobes resume
    @(negedge clk_i) test_en_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R7 exit keeps phase", int'(phase_o), 8);
    pulses = 0;
    for (int i = 0; i < 64; i++) tick();
    check("R8 wrap back to phase", int'(phase_o), 8);
    check("R4 one pulse per 64", pulses, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule